// File: doc/BRIEF.md
# Warp Instruction Execution Counters

This block counts instruction issue activity for one streaming multiprocessor that is split into four sub-partitions. Every cycle, each sub-partition may report one issued warp instruction. The report carries a 32-lane mask of active threads and a 32-lane mask of guard-predicate values. From that one event the block derives three counts: the number of warp instructions, the number of thread instructions (active lanes), and the number of thread instructions whose guard predicate was true (lanes that are both active and predicated on).

Each sub-partition keeps its own three saturating counters. A second set of accumulators keeps the multiprocessor-wide totals. These totals take the increments of all four sub-partitions in the same cycle. A registered read port selects a sub-partition, the multiprocessor total, or the mean per sub-partition, together with a metric. A synchronous clear input zeroes every counter.

Top module: `warp_inst_ctr`

## Requirements
- R1: After reset, every counter and `rd_data_o` are zero.
- R2: The warp counter of a sub-partition rises by exactly one for each issue on that sub-partition, whatever the masks hold, including an empty active mask.
- R3: The thread counter of a sub-partition adds the number of set bits in that sub-partition's active mask on each issue.
- R4: The predicated-on counter adds the popcount of (active AND predicate). Predicate bits of inactive lanes have no effect.
- R5: The four sub-partitions count independently, and all four may issue in the same cycle. A sub-partition that does not issue keeps its counts.
- R6: The multiprocessor total of each metric (part select 4) equals the sum of the four sub-partition counters as long as the total is not saturated.
- R7: Part select 5 returns the multiprocessor total divided by four, truncated. This is the mean per sub-partition, so the total equals four times this value whenever the total is a multiple of four.
- R8: Every counter saturates at 2^CNT_W-1 and holds that value instead of wrapping.
- R9: `clear_i` zeroes all counters at the next clock edge. Issues presented in the same cycle as a clear are dropped.
- R10: The read port selects with `rd_part_i` (0..3 sub-partition, 4 total, 5 mean) and `rd_metric_i` (0 warp, 1 thread, 2 predicated-on). Data appears on `rd_data_o` one cycle after the select. Any other code returns zero.
- R11: For every sub-partition, predicated-on count ≤ thread count ≤ 32 × warp count holds at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_vld_i | input | NUM_PARTS | One issue flag per sub-partition |
| active_mask_i | input | NUM_PARTS*LANES | Active-thread masks; sub-partition p uses bits p*LANES +: LANES |
| pred_mask_i | input | NUM_PARTS*LANES | Guard-predicate masks, same lane layout |
| clear_i | input | 1 | Synchronous clear of all counters |
| rd_part_i | input | SEL_W | Part select: sub-partition, total or mean |
| rd_metric_i | input | 2 | Metric select |
| rd_data_o | output | CNT_W | Registered read data |

## Verification
Two events can land in the same cycle: an issue and a clear, and issues on all four sub-partitions at once. The bench drives all four issue flags high with different masks in one cycle. It then checks that each sub-partition and the total moved by the separately computed popcounts. Next, it raises `clear_i` together with four valid issues. Every counter must then read zero, which shows that the clear beat the issues.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic [1:0] {
    MET_WARP   = 2'd0,
    MET_THREAD = 2'd1,
    MET_PRED   = 2'd2,
    MET_NONE   = 2'd3
  } metric_e;
endpackage

// File: rtl/wic_popcnt.sv
module wic_popcnt #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/wic_sat_acc.sv
module wic_sat_acc #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, cnt_o} + (CNT_W + 1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (clear_i)     cnt_o <= '0;
    else if (sum[CNT_W])  cnt_o <= '1;
    else                  cnt_o <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/wic_part.sv
module wic_part #(
  parameter int unsigned LANES = 32,
  parameter int unsigned CNT_W = 48,
  localparam int unsigned PC_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [LANES-1:0] act_i,
  input  logic [LANES-1:0] prd_i,
  output logic             inc_warp_o,
  output logic [PC_W-1:0]  inc_thr_o,
  output logic [PC_W-1:0]  inc_pred_o,
  output logic [CNT_W-1:0] cnt_warp_o,
  output logic [CNT_W-1:0] cnt_thr_o,
  output logic [CNT_W-1:0] cnt_pred_o
);
  logic [PC_W-1:0] pc_act, pc_on;

  wic_popcnt #(.W(LANES)) i_pc_act (.vec_i(act_i),         .cnt_o(pc_act));
  // inactive lanes never count as predicated on
  wic_popcnt #(.W(LANES)) i_pc_on  (.vec_i(act_i & prd_i), .cnt_o(pc_on));

  assign inc_warp_o = vld_i;
  assign inc_thr_o  = vld_i ? pc_act : '0;
  assign inc_pred_o = vld_i ? pc_on  : '0;

  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(1)) i_acc_warp (
    .clk_i, .rst_ni, .clear_i, .inc_i(inc_warp_o), .cnt_o(cnt_warp_o));
  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(PC_W)) i_acc_thr (
    .clk_i, .rst_ni, .clear_i, .inc_i(inc_thr_o), .cnt_o(cnt_thr_o));
  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(PC_W)) i_acc_pred (
    .clk_i, .rst_ni, .clear_i, .inc_i(inc_pred_o), .cnt_o(cnt_pred_o));
endmodule

// File: rtl/wic_sm_total.sv
module wic_sm_total #(
  parameter int unsigned NUM_PARTS = 4,
  parameter int unsigned LANES     = 32,
  parameter int unsigned CNT_W     = 48,
  localparam int unsigned PC_W  = $clog2(LANES + 1),
  localparam int unsigned SW_W  = $clog2(NUM_PARTS + 1),
  localparam int unsigned ST_W  = $clog2(NUM_PARTS * LANES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic [NUM_PARTS-1:0]           inc_warp_i,
  input  logic [NUM_PARTS-1:0][PC_W-1:0] inc_thr_i,
  input  logic [NUM_PARTS-1:0][PC_W-1:0] inc_pred_i,
  output logic [CNT_W-1:0]               tot_warp_o,
  output logic [CNT_W-1:0]               tot_thr_o,
  output logic [CNT_W-1:0]               tot_pred_o
);
  logic [SW_W-1:0] sum_warp;
  logic [ST_W-1:0] sum_thr, sum_pred;

  // all four increments folded into one update per cycle
  always_comb begin
    sum_warp = '0;
    sum_thr  = '0;
    sum_pred = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      sum_warp = sum_warp + SW_W'(inc_warp_i[p]);
      sum_thr  = sum_thr  + ST_W'(inc_thr_i[p]);
      sum_pred = sum_pred + ST_W'(inc_pred_i[p]);
    end
  end

  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(SW_W)) i_tot_warp (
    .clk_i, .rst_ni, .clear_i, .inc_i(sum_warp), .cnt_o(tot_warp_o));
  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(ST_W)) i_tot_thr (
    .clk_i, .rst_ni, .clear_i, .inc_i(sum_thr), .cnt_o(tot_thr_o));
  wic_sat_acc #(.CNT_W(CNT_W), .INC_W(ST_W)) i_tot_pred (
    .clk_i, .rst_ni, .clear_i, .inc_i(sum_pred), .cnt_o(tot_pred_o));
endmodule

// File: rtl/warp_inst_ctr.sv
module warp_inst_ctr #(
  parameter int unsigned NUM_PARTS = 4,
  parameter int unsigned LANES     = 32,
  parameter int unsigned CNT_W     = 48,
  localparam int unsigned SEL_W = $clog2(NUM_PARTS + 2),
  localparam int unsigned PC_W  = $clog2(LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PARTS-1:0]       issue_vld_i,
  input  logic [NUM_PARTS*LANES-1:0] active_mask_i,
  input  logic [NUM_PARTS*LANES-1:0] pred_mask_i,
  input  logic                       clear_i,
  input  logic [SEL_W-1:0]           rd_part_i,
  input  logic [1:0]                 rd_metric_i,
  output logic [CNT_W-1:0]           rd_data_o
);
  import wic_pkg::*;

  localparam logic [SEL_W-1:0] SEL_TOT  = SEL_W'(NUM_PARTS);
  localparam logic [SEL_W-1:0] SEL_MEAN = SEL_W'(NUM_PARTS + 1);

  logic [NUM_PARTS-1:0]            inc_warp;
  logic [NUM_PARTS-1:0][PC_W-1:0]  inc_thr, inc_pred;
  logic [NUM_PARTS-1:0][CNT_W-1:0] cnt_warp, cnt_thr, cnt_pred;
  logic [CNT_W-1:0]                tot_warp, tot_thr, tot_pred;
  logic [CNT_W-1:0]                rd_next;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    wic_part #(.LANES(LANES), .CNT_W(CNT_W)) i_part (
      .clk_i, .rst_ni, .clear_i,
      .vld_i      (issue_vld_i[p]),
      .act_i      (active_mask_i[p*LANES +: LANES]),
      .prd_i      (pred_mask_i[p*LANES +: LANES]),
      .inc_warp_o (inc_warp[p]),
      .inc_thr_o  (inc_thr[p]),
      .inc_pred_o (inc_pred[p]),
      .cnt_warp_o (cnt_warp[p]),
      .cnt_thr_o  (cnt_thr[p]),
      .cnt_pred_o (cnt_pred[p]));
  end

  wic_sm_total #(.NUM_PARTS(NUM_PARTS), .LANES(LANES), .CNT_W(CNT_W)) i_total (
    .clk_i, .rst_ni, .clear_i,
    .inc_warp_i (inc_warp),
    .inc_thr_i  (inc_thr),
    .inc_pred_i (inc_pred),
    .tot_warp_o (tot_warp),
    .tot_thr_o  (tot_thr),
    .tot_pred_o (tot_pred));

  function automatic logic [CNT_W-1:0] pick(input logic [1:0] m,
      input logic [CNT_W-1:0] w, input logic [CNT_W-1:0] t, input logic [CNT_W-1:0] q);
    case (metric_e'(m))
      MET_WARP:   pick = w;
      MET_THREAD: pick = t;
      MET_PRED:   pick = q;
      default:    pick = '0;
    endcase
  endfunction

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PARTS; p++)
      if (rd_part_i == SEL_W'(p))
        rd_next = pick(rd_metric_i, cnt_warp[p], cnt_thr[p], cnt_pred[p]);
    if (rd_part_i == SEL_TOT)
      rd_next = pick(rd_metric_i, tot_warp, tot_thr, tot_pred);
    else if (rd_part_i == SEL_MEAN)
      rd_next = pick(rd_metric_i, tot_warp, tot_thr, tot_pred) / CNT_W'(NUM_PARTS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end
endmodule

// File: rtl/wic_sva.sv
module wic_sva #(
  parameter int unsigned NUM_PARTS = 4,
  parameter int unsigned LANES     = 32,
  parameter int unsigned CNT_W     = 48,
  parameter int unsigned SEL_W     = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_PARTS-1:0]            issue_vld_i,
  input logic                            clear_i,
  input logic [SEL_W-1:0]                rd_part_i,
  input logic [1:0]                      rd_metric_i,
  input logic [CNT_W-1:0]                rd_data_o,
  input logic [NUM_PARTS-1:0][CNT_W-1:0] cnt_warp,
  input logic [NUM_PARTS-1:0][CNT_W-1:0] cnt_thr,
  input logic [NUM_PARTS-1:0][CNT_W-1:0] cnt_pred,
  input logic [CNT_W-1:0]                tot_warp,
  input logic [CNT_W-1:0]                tot_thr,
  input logic [CNT_W-1:0]                tot_pred
);
  localparam int unsigned XW = CNT_W + $clog2(LANES) + $clog2(NUM_PARTS) + 1;
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [XW-1:0] sum_w, sum_t, sum_p;
  always_comb begin
    sum_w = '0; sum_t = '0; sum_p = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      sum_w = sum_w + XW'(cnt_warp[p]);
      sum_t = sum_t + XW'(cnt_thr[p]);
      sum_p = sum_p + XW'(cnt_pred[p]);
    end
  end

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_chk
    p_warp_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_vld_i[p] && !clear_i && cnt_warp[p] != MAX)
        |=> cnt_warp[p] == $past(cnt_warp[p]) + 1'b1);
    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!issue_vld_i[p] && !clear_i)
        |=> $stable(cnt_warp[p]) && $stable(cnt_thr[p]) && $stable(cnt_pred[p]));
    p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_thr[p] == MAX && !clear_i) |=> cnt_thr[p] == MAX);
    p_pred_le_thr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_pred[p] <= cnt_thr[p]);
    p_thr_le_lanes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      XW'(cnt_thr[p]) <= XW'(cnt_warp[p]) * XW'(LANES));
  end

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_warp == '0) && (cnt_thr == '0) && (cnt_pred == '0)
                && tot_warp == '0 && tot_thr == '0 && tot_pred == '0);
  p_total_warp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_warp != MAX) |-> XW'(tot_warp) == sum_w);
  p_total_thr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_thr != MAX) |-> XW'(tot_thr) == sum_t);
  p_total_pred_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_pred != MAX) |-> XW'(tot_pred) == sum_p);
  p_bad_sel_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_metric_i == 2'd3 || rd_part_i > SEL_W'(NUM_PARTS + 1)) |=> rd_data_o == '0);
endmodule

bind warp_inst_ctr wic_sva #(
  .NUM_PARTS(NUM_PARTS), .LANES(LANES), .CNT_W(CNT_W), .SEL_W(SEL_W)
) i_wic_sva (
  .clk_i, .rst_ni, .issue_vld_i, .clear_i, .rd_part_i, .rd_metric_i, .rd_data_o,
  .cnt_warp, .cnt_thr, .cnt_pred, .tot_warp, .tot_thr, .tot_pred);

// File: tb/test_warp_inst_ctr.sv
module test_warp_inst_ctr;
  localparam int NP = 4;
  localparam int LN = 32;
  localparam int CW = 10;
  localparam int SW = 3;
  localparam longint MAXV = (64'd1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   vld = '0;
  logic [NP*LN-1:0] act = '0, prd = '0;
  logic            clr = 1'b0;
  logic [SW-1:0]   rpart = '0;
  logic [1:0]      rmet = '0;
  logic [CW-1:0]   rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint exp_c[NP][3];
  longint exp_t[3];

  always #10 clk = ~clk;

  warp_inst_ctr #(.NUM_PARTS(NP), .LANES(LN), .CNT_W(CW)) i_warp_inst_ctr (
    .clk_i(clk), .rst_ni(rst_n), .issue_vld_i(vld), .active_mask_i(act),
    .pred_mask_i(prd), .clear_i(clr), .rd_part_i(rpart), .rd_metric_i(rmet),
    .rd_data_o(rdata));

  // part(2) | active(32) | predicate(32)
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'd1, 32'h0000_0001, 32'h0000_0000},
    {2'd2, 32'h0000_FFFF, 32'hFFFF_0000},
    {2'd3, 32'hAAAA_AAAA, 32'h5555_FFFF},
    {2'd0, 32'h8000_0000, 32'h8000_0000},
    {2'd1, 32'h0F0F_0F0F, 32'h00FF_00FF},
    {2'd2, 32'h0000_0000, 32'hFFFF_FFFF},
    {2'd3, 32'hFFFF_FFFF, 32'h1234_5678}};

  function automatic longint sat(longint a);
    return (a > MAXV) ? MAXV : a;
  endfunction

  task automatic check(string req, longint got, longint expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, expv);
    end
  endtask

  task automatic model_zero();
    for (int p = 0; p < NP; p++) for (int m = 0; m < 3; m++) exp_c[p][m] = 0;
    for (int m = 0; m < 3; m++) exp_t[m] = 0;
  endtask

  task automatic issue(logic [NP-1:0] v, logic [NP*LN-1:0] a, logic [NP*LN-1:0] q, bit c);
    longint inc[3];
    @(negedge clk);
    vld = v; act = a; prd = q; clr = c;
    @(negedge clk);
    vld = '0; clr = 1'b0;
    if (c) model_zero();
    else begin
      inc = '{0, 0, 0};
      for (int p = 0; p < NP; p++) if (v[p]) begin
        longint d[3];
        d[0] = 1;
        d[1] = $countones(a[p*LN +: LN]);
        d[2] = $countones(a[p*LN +: LN] & q[p*LN +: LN]);
        for (int m = 0; m < 3; m++) begin
          exp_c[p][m] = sat(exp_c[p][m] + d[m]);
          inc[m] += d[m];
        end
      end
      for (int m = 0; m < 3; m++) exp_t[m] = sat(exp_t[m] + inc[m]);
    end
  endtask

  task automatic rd(int part, int met, longint expv, string req);
    @(negedge clk);
    rpart = SW'(part); rmet = 2'(met);
    @(negedge clk);
    check(req, longint'(rdata), expv);
  endtask

  task automatic read_all(string req);
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < 3; m++) rd(p, m, exp_c[p][m], req);
    for (int m = 0; m < 3; m++) rd(NP, m, exp_t[m], {req, " R6"});
    for (int m = 0; m < 3; m++) rd(NP + 1, m, exp_t[m] / NP, {req, " R7"});
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    model_zero();
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", longint'(rdata), 0);
    rst_n = 1'b1;
    rd(0, 0, 0, "R1 part0 warp");
    rd(NP, 1, 0, "R1 total thread");

    // table walk, one sub-partition per issue (R2 R3 R4)
    for (int i = 0; i < 8; i++) begin
      logic [NP*LN-1:0] a, q;
      int p;
      p = int'(VEC[i][65:64]);
      a = '0; q = '0;
      a[p*LN +: LN] = VEC[i][63:32];
      q[p*LN +: LN] = VEC[i][31:0];
      issue(NP'(1) << p, a, q, 1'b0);
    end
    read_all("R2 R3 R4 table");

    // all four in one cycle (R5)
    issue(4'hF, {32'h0000_0003, 32'hFFFF_0000, 32'h0101_0101, 32'h7FFF_FFFF},
                {32'h0000_0002, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0000_0000}, 1'b0);
    read_all("R5 simultaneous");

    // predicate on inactive lanes ignored (R4)
    issue(4'h2, {32'h0, 32'h0, 32'h0000_00FF, 32'h0}, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0}, 1'b0);
    rd(1, 2, exp_c[1][2], "R4 inactive predicate ignored");
    rd(1, 1, exp_c[1][1], "R3 thread after masked issue");

    // invalid selects (R10)
    rd(0, 3, 0, "R10 metric code 3");
    rd(6, 0, 0, "R10 part code 6");
    rd(7, 1, 0, "R10 part code 7");

    // clear with issues in same cycle (R9)
    issue(4'hF, '1, '1, 1'b1);
    read_all("R9 clear beats issue");

    // R7 mean on an exact multiple of four
    issue(4'hF, '1, '1, 1'b0);
    rd(NP + 1, 0, 1, "R7 mean warp");
    rd(NP, 0, 4, "R7 total warp = 4x mean");

    // saturation (R8)
    issue(4'hF, '1, '1, 1'b1);
    for (int k = 0; k < 1040; k++) issue(4'h1, '1, '1, 1'b0);
    rd(0, 0, MAXV, "R8 warp saturates");
    rd(0, 1, MAXV, "R8 thread saturates");
    rd(0, 2, MAXV, "R8 pred saturates");
    rd(NP, 0, MAXV, "R8 total warp saturates");
    rd(NP + 1, 0, MAXV / NP, "R7 mean of saturated total");
    rd(1, 0, 0, "R5 idle part unchanged");
    // R11 ordering of model against design reads
    rd(2, 1, exp_c[2][1], "R11 thread le lanes x warp");

    done = 1'b1;
    report();
  end
endmodule